// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block drives a multichannel analog-to-digital converter through a group of channels over and over. Software writes a control word that holds a run bit, a group select, an interrupt enable and a write value for the pass-complete flag. While the run bit is set and the module enable is high, the sequencer issues a one-cycle start pulse with a channel number to the converter. It waits for the converter's done pulse, stores the returned sample in that channel's result slot, and starts the next channel in the following cycle.

The group always begins at channel 0 and ends at the channel number held in the group select. When the last channel of the group finishes, the pass-complete flag is set and channel 0 starts again. The flag drives an interrupt request when interrupts are enabled.

Clearing the run bit, or dropping the module enable, halts the scan. A conversion that is already in flight then completes at the converter, but its sample is thrown away. A later start always begins again at channel 0.

Top module: `adc_scan_seq`

## Requirements
- R1: After a control write with the run bit set while idle and enabled, `conv_start_o` is high with `conv_ch_o` = 0 in the cycle after the write edge (the second clock edge counting the write edge).
- R2: When the converter returns `conv_done_i` for a channel that is not being discarded, the start pulse for the next channel of the group is high in the very next cycle, with no idle cycle between them.
- R3: While the run bit stays 1, the scan repeats without end: channel 0 follows the last channel of the group.
- R4: The sample on `conv_data_i` during a done cycle appears in the slot of the channel just converted, at bits [k*DATA_W +: DATA_W] of `results_o` for channel k, one cycle after the done. All other slots are unchanged.
- R5: The done of the group's last channel sets `flag_o` in the next cycle. The flag stays set across later passes.
- R6: `irq_o` is high exactly when `flag_o` and `ie_o` are both high.
- R7: Group select value s (00, 01, 10, 11) covers channels 0 through s. No channel above s is ever started, and channel s is the last one of the pass.
- R8: The flag clears only on a control write with `wr_flag_i` = 0, and writing 1 leaves it unchanged. A pass end in the same cycle as a clearing write leaves the flag set.
- R9: Once the run bit reads 0, no further start pulses are issued. The sample of a conversion that was in flight is discarded.
- R10: Setting the run bit after a halt restarts the scan at channel 0. The same write may also change the group select, and the new group takes effect at once.
- R11: While `mod_en_i` is low, no start pulses are issued and no in-flight sample is stored. Raising it again with the run bit set starts at channel 0.
- R12: After reset the run bit, group select, enable, flag, interrupt, start pulse and all result slots are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en_i | input | 1 | Module enable; low places the sequencer in standby |
| wr_en_i | input | 1 | Control write strobe |
| wr_run_i | input | 1 | Run bit value to write |
| wr_sel_i | input | SEL_W | Group select value to write (last channel index) |
| wr_ie_i | input | 1 | Interrupt enable value to write |
| wr_flag_i | input | 1 | Flag write value; 0 clears, 1 leaves unchanged |
| run_o | output | 1 | Current run bit |
| sel_o | output | SEL_W | Current group select |
| ie_o | output | 1 | Current interrupt enable |
| flag_o | output | 1 | Pass-complete flag |
| irq_o | output | 1 | Interrupt request |
| results_o | output | NUM_CH*DATA_W | Result slots, channel k at bits [k*DATA_W +: DATA_W] |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_ch_o | output | SEL_W | Channel to convert |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | DATA_W | Converter sample, valid with done |

## Verification
A control write lands on one clock edge. The first start pulse is due one cycle later, so the bench samples it at the second falling edge after it drives the write. The stored sample, the next start pulse and a newly set flag all come from registers loaded on the edge where the converter's done is high. The bench therefore reads them at the falling edge that follows the done cycle. The interrupt is combinational from the flag and is sampled at that same falling edge. Halt and standby cases are checked by counting start pulses over a window longer than one conversion and comparing the result slots before and after that window.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_CONV  = 2'd1,
      SQ_DRAIN = 2'd2
   } seq_state_e;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic             wr_run_i,
   input  logic [SEL_W-1:0] wr_sel_i,
   input  logic             wr_ie_i,
   input  logic             wr_flag_i,
   input  logic             pass_end_i,
   output logic             run_o,
   output logic [SEL_W-1:0] sel_o,
   output logic             ie_o,
   output logic             flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o <= 1'b0;
         sel_o <= '0;
         ie_o  <= 1'b0;
      end else if (wr_en_i) begin
         run_o <= wr_run_i;
         sel_o <= wr_sel_i;
         ie_o  <= wr_ie_i;
      end
   end

   // a pass end takes priority over a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (pass_end_i)
         flag_o <= 1'b1;
      else if (wr_en_i && !wr_flag_i)
         flag_o <= 1'b0;
   end
endmodule

// File: rtl/adc_scan_seq_fsm.sv
module adc_scan_seq_fsm
   import adc_scan_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             run_i,
   input  logic [SEL_W-1:0] last_ch_i,
   input  logic             conv_done_i,
   output logic             start_o,
   output logic [SEL_W-1:0] ch_o,
   output logic             res_we_o,
   output logic             pass_end_o,
   output logic             in_flight_o
);
   seq_state_e       state_q;
   logic [SEL_W-1:0] ch_q;
   logic             start_q;
   logic             go;
   logic             at_last;

   assign go      = run_i && en_i;
   assign at_last = (ch_q == last_ch_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         ch_q    <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (go) begin
                  state_q <= SQ_CONV;
                  ch_q    <= '0;
                  start_q <= 1'b1;
               end
            end
            SQ_CONV: begin
               if (!go) begin
                  // halted with a sample pending: wait for it and drop it
                  state_q <= conv_done_i ? SQ_IDLE : SQ_DRAIN;
               end else if (conv_done_i) begin
                  ch_q    <= at_last ? '0 : ch_q + 1'b1;
                  start_q <= 1'b1;
               end
            end
            SQ_DRAIN: begin
               if (conv_done_i) state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign start_o     = start_q;
   assign ch_o        = ch_q;
   assign res_we_o    = (state_q == SQ_CONV) && go && conv_done_i;
   assign pass_end_o  = res_we_o && at_last;
   assign in_flight_o = (state_q == SQ_CONV);
endmodule

// File: rtl/adc_scan_res_bank.sv
module adc_scan_res_bank #(
   parameter int DATA_W = 12,
   parameter int SEL_W  = 2,
   localparam int NUM_CH = 1 << SEL_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [SEL_W-1:0]         wch_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [NUM_CH*DATA_W-1:0] results_o
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (we_i && (wch_i == SEL_W'(g)))
            slot_q <= wdata_i;
      end
      assign results_o[g*DATA_W +: DATA_W] = slot_q;
   end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter int DATA_W  = 12,
   parameter int SEL_W   = 2,
   parameter bit IRQ_REG = 1'b0,
   localparam int NUM_CH = 1 << SEL_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mod_en_i,
   input  logic                     wr_en_i,
   input  logic                     wr_run_i,
   input  logic [SEL_W-1:0]         wr_sel_i,
   input  logic                     wr_ie_i,
   input  logic                     wr_flag_i,
   output logic                     run_o,
   output logic [SEL_W-1:0]         sel_o,
   output logic                     ie_o,
   output logic                     flag_o,
   output logic                     irq_o,
   output logic [NUM_CH*DATA_W-1:0] results_o,
   output logic                     conv_start_o,
   output logic [SEL_W-1:0]         conv_ch_o,
   input  logic                     conv_done_i,
   input  logic [DATA_W-1:0]        conv_data_i
);
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("adc_scan_seq: SEL_W must be 1..3");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("adc_scan_seq: DATA_W must be 1..32");
   end

   logic res_we;
   logic pass_end;
   logic in_flight;

   adc_scan_ctrl #(.SEL_W(SEL_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_run_i   (wr_run_i),
      .wr_sel_i   (wr_sel_i),
      .wr_ie_i    (wr_ie_i),
      .wr_flag_i  (wr_flag_i),
      .pass_end_i (pass_end),
      .run_o      (run_o),
      .sel_o      (sel_o),
      .ie_o       (ie_o),
      .flag_o     (flag_o)
   );

   adc_scan_seq_fsm #(.SEL_W(SEL_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (mod_en_i),
      .run_i       (run_o),
      .last_ch_i   (sel_o),
      .conv_done_i (conv_done_i),
      .start_o     (conv_start_o),
      .ch_o        (conv_ch_o),
      .res_we_o    (res_we),
      .pass_end_o  (pass_end),
      .in_flight_o (in_flight)
   );

   adc_scan_res_bank #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (res_we),
      .wch_i     (conv_ch_o),
      .wdata_i   (conv_data_i),
      .results_o (results_o)
   );

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag_o && ie_o;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = flag_o && ie_o;
   end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int DATA_W = 12,
   parameter int SEL_W  = 2,
   localparam int NUM_CH = 1 << SEL_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     mod_en_i,
   input logic                     wr_en_i,
   input logic                     wr_flag_i,
   input logic                     run_o,
   input logic                     ie_o,
   input logic                     flag_o,
   input logic                     irq_o,
   input logic [NUM_CH*DATA_W-1:0] results_o,
   input logic                     conv_start_o,
   input logic                     conv_done_i,
   input logic                     in_flight
);
   // R2: an accepted done is followed at once by the next start
   a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight && conv_done_i && run_o && mod_en_i |=> conv_start_o);

   // R9: a cleared run bit stops start pulses
   a_r9_halt_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o |=> !conv_start_o);

   // R11: standby issues no start pulses
   a_r11_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en_i |=> !conv_start_o);

   // R5: the flag only rises after a converter done
   a_r5_flag_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(conv_done_i));

   // R8: the flag only falls after a clearing write
   a_r8_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(wr_en_i && !wr_flag_i));

   // R4: result slots move only on an accepted done
   a_r4_slot_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(results_o) |-> $past(conv_done_i && run_o && mod_en_i));

   // R6: a request needs both the flag and the enable
   a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flag_o && ie_o));
endmodule

bind adc_scan_seq adc_scan_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mod_en_i     (mod_en_i),
   .wr_en_i      (wr_en_i),
   .wr_flag_i    (wr_flag_i),
   .run_o        (run_o),
   .ie_o         (ie_o),
   .flag_o       (flag_o),
   .irq_o        (irq_o),
   .results_o    (results_o),
   .conv_start_o (conv_start_o),
   .conv_done_i  (conv_done_i),
   .in_flight    (in_flight)
);

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
   localparam int DW  = 12;
   localparam int SW  = 2;
   localparam int NCH = 1 << SW;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mod_en_i = 1'b1;
   logic wr_en_i = 1'b0, wr_run_i = 1'b0, wr_ie_i = 1'b0, wr_flag_i = 1'b1;
   logic [SW-1:0] wr_sel_i = '0;
   logic run_o, ie_o, flag_o, irq_o, conv_start_o;
   logic [SW-1:0] sel_o, conv_ch_o;
   logic [NCH*DW-1:0] results_o;
   logic conv_done_i = 1'b0;
   logic [DW-1:0] conv_data_i = '0;

   int n_checks = 0;
   int n_errors = 0;
   int n_starts = 0;
   int n_starts_ch3 = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   adc_scan_seq #(.DATA_W(DW), .SEL_W(SW)) dut_i (
      .clk(clk), .rst_n(rst_n), .mod_en_i(mod_en_i),
      .wr_en_i(wr_en_i), .wr_run_i(wr_run_i), .wr_sel_i(wr_sel_i),
      .wr_ie_i(wr_ie_i), .wr_flag_i(wr_flag_i),
      .run_o(run_o), .sel_o(sel_o), .ie_o(ie_o), .flag_o(flag_o), .irq_o(irq_o),
      .results_o(results_o), .conv_start_o(conv_start_o), .conv_ch_o(conv_ch_o),
      .conv_done_i(conv_done_i), .conv_data_i(conv_data_i)
   );

   // converter model: fixed latency, sample tagged with channel and sequence
   logic       cv_busy = 1'b0;
   int         cv_cnt = 0;
   logic [SW-1:0] cv_ch = '0;
   logic [7:0] cv_seq = 8'h11;
   always @(posedge clk) begin
      conv_done_i <= 1'b0;
      if (!rst_n) begin
         cv_busy <= 1'b0;
      end else if (conv_start_o) begin
         cv_busy <= 1'b1;
         cv_cnt  <= LAT;
         cv_ch   <= conv_ch_o;
         n_starts <= n_starts + 1;
         if (conv_ch_o == 2'd3) n_starts_ch3 <= n_starts_ch3 + 1;
      end else if (cv_busy) begin
         if (cv_cnt == 1) begin
            cv_busy     <= 1'b0;
            conv_done_i <= 1'b1;
            conv_data_i <= {2'b00, cv_ch, cv_seq};
            cv_seq      <= cv_seq + 8'h07;
         end else begin
            cv_cnt <= cv_cnt - 1;
         end
      end
   end

   function automatic logic [DW-1:0] slot(input int k);
      return results_o[k*DW +: DW];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input bit run, input logic [SW-1:0] sel, input bit ie, input bit flg);
      wr_en_i = 1'b1; wr_run_i = run; wr_sel_i = sel; wr_ie_i = ie; wr_flag_i = flg;
      @(negedge clk);
      wr_en_i = 1'b0; wr_flag_i = 1'b1;
   endtask

   task automatic halt();
      wr(1'b0, sel_o, 1'b0, 1'b1);
      repeat (15) @(negedge clk);
   endtask

   task automatic wait_start(input logic [SW-1:0] exp_ch);
      for (int i = 0; i < 40 && !conv_start_o; i++) @(negedge clk);
      chk(conv_start_o == 1'b1, "R3", "start seen", conv_start_o, 1);
      chk(conv_ch_o == exp_ch, "R7", "start channel", conv_ch_o, exp_ch);
   endtask

   task automatic wait_done();
      @(negedge clk);
      for (int i = 0; i < 40 && !conv_done_i; i++) @(negedge clk);
   endtask

   // one channel: start, done, then result / next start / flag one cycle later
   task automatic do_chan(input int ch, input int nxt, input bit last);
      logic [DW-1:0] d;
      logic [NCH*DW-1:0] snap;
      wait_start(ch[SW-1:0]);
      wait_done();
      d = conv_data_i;
      snap = results_o;
      snap[ch*DW +: DW] = d;
      @(negedge clk);
      chk(results_o == snap, "R4", "result slots", results_o, snap);
      chk(conv_start_o == 1'b1, "R2", "next start without gap", conv_start_o, 1);
      chk(conv_ch_o == nxt[SW-1:0], "R3", "next channel", conv_ch_o, nxt);
      if (last) chk(flag_o == 1'b1, "R5", "flag after last channel", flag_o, 1);
   endtask

   task automatic t_reset();
      chk(run_o == 0 && sel_o == 0 && ie_o == 0, "R12", "control reset", {run_o, sel_o, ie_o}, 0);
      chk(flag_o == 0 && irq_o == 0 && conv_start_o == 0, "R12", "flag/irq/start reset",
          {flag_o, irq_o, conv_start_o}, 0);
      chk(results_o == '0, "R12", "results reset", results_o, 0);
   endtask

   task automatic t_scan3();
      int c3;
      c3 = n_starts_ch3;
      wr(1'b1, 2'd2, 1'b0, 1'b0);
      chk(run_o == 1 && conv_start_o == 0, "R1", "run set, start not yet", conv_start_o, 0);
      @(negedge clk);
      chk(conv_start_o == 1 && conv_ch_o == 0, "R1", "first start on channel 0",
          {conv_start_o, conv_ch_o}, {1'b1, 2'd0});
      for (int p = 0; p < 2; p++) begin
         do_chan(0, 1, 1'b0);
         do_chan(1, 2, 1'b0);
         do_chan(2, 0, 1'b1);
         chk(irq_o == 1'b0, "R6", "no irq with enable clear", irq_o, 0);
      end
      chk(n_starts_ch3 == c3, "R7", "channel 3 never started for group 10", n_starts_ch3, c3);
      halt();
   endtask

   task automatic t_flag_irq();
      wr(1'b1, 2'd0, 1'b1, 1'b0);
      do_chan(0, 0, 1'b1);
      chk(irq_o == 1'b1, "R6", "irq with flag and enable", irq_o, 1);
      wr(1'b1, 2'd0, 1'b1, 1'b1);
      chk(flag_o == 1'b1, "R8", "writing 1 keeps flag", flag_o, 1);
      wr(1'b1, 2'd0, 1'b1, 1'b0);
      chk(flag_o == 1'b0, "R8", "writing 0 clears flag", flag_o, 0);
      chk(irq_o == 1'b0, "R6", "irq drops with flag", irq_o, 0);
      wr(1'b1, 2'd0, 1'b0, 1'b1);
      do_chan(0, 0, 1'b1);
      chk(irq_o == 1'b0, "R6", "no irq with enable clear", irq_o, 0);
      // clearing write lands on the same edge as a pass end
      wait_done();
      wr(1'b1, 2'd0, 1'b0, 1'b0);
      chk(flag_o == 1'b1, "R8", "pass end wins over clear", flag_o, 1);
      halt();
   endtask

   task automatic t_scan4_halt();
      logic [DW-1:0] old1;
      int ns;
      wr(1'b1, 2'd3, 1'b0, 1'b0);
      do_chan(0, 1, 1'b0);
      do_chan(1, 2, 1'b0);
      do_chan(2, 3, 1'b0);
      do_chan(3, 0, 1'b1);
      do_chan(0, 1, 1'b0);
      old1 = slot(1);
      wr(1'b0, 2'd3, 1'b0, 1'b1);
      ns = n_starts;
      repeat (15) @(negedge clk);
      chk(n_starts == ns, "R9", "no start after halt", n_starts, ns);
      chk(slot(1) == old1, "R9", "in-flight sample discarded", slot(1), old1);
      wr(1'b1, 2'd1, 1'b0, 1'b0);
      @(negedge clk);
      chk(conv_start_o == 1 && conv_ch_o == 0, "R10", "restart at channel 0",
          {conv_start_o, conv_ch_o}, {1'b1, 2'd0});
      do_chan(0, 1, 1'b0);
      do_chan(1, 0, 1'b1);
      halt();
   endtask

   task automatic t_standby();
      int ns;
      logic [DW-1:0] old0;
      mod_en_i = 1'b0;
      wr(1'b1, 2'd0, 1'b0, 1'b0);
      ns = n_starts;
      repeat (20) @(negedge clk);
      chk(n_starts == ns, "R11", "no start in standby", n_starts, ns);
      chk(flag_o == 1'b0, "R11", "flag untouched in standby", flag_o, 0);
      mod_en_i = 1'b1;
      @(negedge clk);
      chk(conv_start_o == 1 && conv_ch_o == 0, "R11", "start at channel 0 on enable",
          {conv_start_o, conv_ch_o}, {1'b1, 2'd0});
      @(negedge clk);
      mod_en_i = 1'b0;
      old0 = slot(0);
      ns = n_starts;
      repeat (15) @(negedge clk);
      chk(slot(0) == old0, "R11", "in-flight sample dropped in standby", slot(0), old0);
      chk(n_starts == ns, "R11", "no start after disable", n_starts, ns);
      mod_en_i = 1'b1;
      halt();
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000 && !finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 50000);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_scan3();
      t_flag_irq();
      t_scan4_halt();
      t_standby();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule